// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This block is a watchdog that can also run as a periodic interval timer. Its 16-bit up-counter is not visible to software. Software reaches the block only through a 16-bit control word. A write takes effect only when the upper byte carries the key 0x5A. Any other upper byte is treated as a sign of runaway code: the block requests a system reset at once. A read returns a fixed 0x69 in the upper byte and the stored settings in the lower byte.

The counter advances on one of two count-enable inputs. The clock generator outside the block supplies these enables. A tap on the counter sets the timeout length. In watchdog mode, expiry requests a one-cycle system reset and returns the settings to their defaults. In interval mode, expiry only raises a sticky interrupt flag, and the count starts again. Two stored bits configure the function of the external reset/NMI pin and are driven out unchanged.

Top module: `wdg_guard`

## Requirements
- R1: `rdData[15:8]` always reads 0x69. `rdData[7:0]` reads the stored control byte, and its bit 3 (counter clear) always reads 0.
- R2: A write with `wrData[15:8]` = 0x5A stores `wrData[7:0]` (bit 3 excepted) from the next cycle on. Control byte fields: bit 7 hold, bit 6 NMI edge, bit 5 NMI select, bit 4 mode (1 = interval), bit 3 counter clear, bit 2 count-enable select, bits 1:0 timeout select. `nmiEdge` and `nmiSel` follow bits 6 and 5.
- R3: A write with any other upper byte raises `rstReq` for exactly one cycle, starting the cycle after the write. It also sets `irqFlag`, returns the control byte to 0x00 and zeroes the counter.
- R4: In watchdog mode (bit 4 = 0), the counter runs out at the enabled count that sets the tapped bit of the incremented value. At that count the block raises `rstReq` for one cycle and sets `irqFlag`. It also returns the control byte to 0x00 and zeroes the counter.
- R5: In interval mode (bit 4 = 1), running out sets `irqFlag`, never raises `rstReq`, and restarts the count from 0, so the flag period repeats.
- R6: Timeout select 00, 01, 10 and 11 taps counter bits 15, 13, 9 and 6. From a zero count this gives 32768, 8192, 512 and 64 enabled counts.
- R7: A keyed write with bit 3 set zeroes the counter. If it lands in the same cycle as a run-out, the write wins and no run-out occurs.
- R8: While hold (bit 7) is set, the counter does not advance and no run-out occurs.
- R9: Count-enable select 0 counts on `tickA` and 1 counts on `tickB`. The other input has no effect.
- R10: `irqFlag` stays set until `flagClr` or `rstN`. A set in the same cycle as `flagClr` leaves the flag set.
- R11: While `rstN` is low and after it is released, the control byte is 0x00 (watchdog mode, hold off, 32768-count timeout), and `irqFlag` and `rstReq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low power-on / pin reset |
| wrEn | input | 1 | Control-word write strobe |
| wrData | input | 16 | Control word: key in [15:8], settings in [7:0] |
| flagClr | input | 1 | Clears the interrupt flag |
| tickA | input | 1 | Count enable, source 0 |
| tickB | input | 1 | Count enable, source 1 |
| rdData | output | 16 | Read value: 0x69 and stored control byte |
| rstReq | output | 1 | One-cycle system reset request |
| irqFlag | output | 1 | Sticky run-out / key-violation flag |
| nmiSel | output | 1 | Reset/NMI pin function select |
| nmiEdge | output | 1 | Reset/NMI pin edge select |

## Verification
A control-word write can land in the very cycle the counter runs out. A keyed clear must suppress the run-out, while a bad key must still give a single reset pulse. The bench provokes this on purpose by issuing a clearing write on the 512th enabled count of a watchdog timeout. Random writes mixed with continuous ticks and short timeouts collide many more times. A second collision is a flag set meeting `flagClr`. A bench model built from the requirements judges every cycle and must see the flag stay set.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CTL_W = 8;
  localparam int B_HOLD = 7;
  localparam int B_NMIEDGE = 6;
  localparam int B_NMISEL = 5;
  localparam int B_MODE = 4;
  localparam int B_CLR = 3;
  localparam int B_CLKSEL = 2;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic clr;
    logic inc;
    logic [SEL_W-1:0] tapSel;
  } wdgStrobe_t;
endpackage

// File: rtl/wdg_count.sv
module wdg_count
  import wdg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TAP0 = 15,
  parameter int TAP1 = 13,
  parameter int TAP2 = 9,
  parameter int TAP3 = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdgStrobe_t stb,
  output logic       tapHit
);
  localparam int N_TAP = 2 ** SEL_W;
  localparam int TAP_POS [N_TAP] = '{TAP0, TAP1, TAP2, TAP3};

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntInc;
  logic [N_TAP-1:0] tapVec;

  assign cntInc = cntQ + 1'b1;

  // one tap candidate per timeout select code
  for (genvar g = 0; g < N_TAP; g++) begin : gTap
    assign tapVec[g] = cntInc[TAP_POS[g]];
  end

  assign tapHit = stb.inc & tapVec[stb.tapSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else if (stb.clr || tapHit) cntQ <= '0;
    else if (stb.inc) cntQ <= cntInc;
  end
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter logic [CTL_W-1:0] KEY = 8'h5A
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2*CTL_W-1:0] wrData,
  input  logic               flagClr,
  input  logic               tickA,
  input  logic               tickB,
  input  logic               tapHit,
  output wdgStrobe_t         stb,
  output logic [CTL_W-1:0]   ctlQ,
  output logic               rstReq,
  output logic               irqFlag
);
  logic keyOk, keyBad, clrWr, expire, puc, tickSel;

  assign keyOk  = wrEn && (wrData[2*CTL_W-1:CTL_W] == KEY);
  assign keyBad = wrEn && (wrData[2*CTL_W-1:CTL_W] != KEY);
  assign clrWr  = keyOk && wrData[B_CLR];
  // a keyed clear or bad key in the same cycle cancels a run-out
  assign expire = tapHit && !keyBad && !clrWr;
  assign puc    = keyBad || (expire && !ctlQ[B_MODE]);

  assign tickSel    = ctlQ[B_CLKSEL] ? tickB : tickA;
  assign stb.inc    = tickSel && !ctlQ[B_HOLD];
  assign stb.clr    = keyBad || clrWr;
  assign stb.tapSel = ctlQ[SEL_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ    <= '0;
      rstReq  <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      rstReq <= puc;
      if (puc) ctlQ <= '0;
      else if (keyOk) begin
        ctlQ        <= wrData[CTL_W-1:0];
        ctlQ[B_CLR] <= 1'b0;
      end
      if (keyBad || expire) irqFlag <= 1'b1;
      else if (flagClr) irqFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TAP0 = 15,
  parameter int TAP1 = 13,
  parameter int TAP2 = 9,
  parameter int TAP3 = 6,
  parameter logic [7:0] KEY = 8'h5A,
  parameter logic [7:0] RD_KEY = 8'h69
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        flagClr,
  input  logic        tickA,
  input  logic        tickB,
  output logic [15:0] rdData,
  output logic        rstReq,
  output logic        irqFlag,
  output logic        nmiSel,
  output logic        nmiEdge
);
  wdgStrobe_t stb;
  logic tapHit;
  logic [CTL_W-1:0] ctlQ;

  wdg_ctrl #(.KEY(KEY)) ctrlU (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .flagClr(flagClr),
    .tickA(tickA), .tickB(tickB), .tapHit(tapHit), .stb(stb), .ctlQ(ctlQ),
    .rstReq(rstReq), .irqFlag(irqFlag)
  );

  wdg_count #(.CNT_W(CNT_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)) dpU (
    .clk(clk), .rstN(rstN), .stb(stb), .tapHit(tapHit)
  );

  assign rdData  = {RD_KEY, ctlQ};
  assign nmiSel  = ctlQ[B_NMISEL];
  assign nmiEdge = ctlQ[B_NMIEDGE];
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic        flagClr,
  input logic [15:0] rdData,
  input logic        rstReq,
  input logic        irqFlag
);
  AST_READ_KEY: assert property (@(posedge clk) disable iff (!rstN)
    rdData[15:8] == 8'h69 && !rdData[3]); // R1
  AST_BAD_KEY_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[15:8] != 8'h5A) |=> (rstReq && irqFlag && rdData[7:0] == 8'h00)); // R3
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R4
  AST_INTERVAL_NO_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[4] && !wrEn) |=> !rstReq); // R5
  AST_CTL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[4] && !wrEn) |=> $stable(rdData)); // R2
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] && !wrEn && !flagClr) |=> ($stable(irqFlag) && !rstReq)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag); // R10
endmodule

bind wdg_guard wdg_guard_chk chkU (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .flagClr(flagClr),
  .rdData(rdData), .rstReq(rstReq), .irqFlag(irqFlag)
);

// File: tb/tb_wdg_guard.sv
module tb_wdg_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic flagClr = 1'b0, tickA = 1'b0, tickB = 1'b0;
  logic [15:0] rdData;
  logic rstReq, irqFlag, nmiSel, nmiEdge;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  wdg_guard dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .flagClr(flagClr),
    .tickA(tickA), .tickB(tickB), .rdData(rdData), .rstReq(rstReq),
    .irqFlag(irqFlag), .nmiSel(nmiSel), .nmiEdge(nmiEdge)
  );

  // timeout select encoding from R6
  function automatic int tapOf(input logic [1:0] sel);
    case (sel)
      2'd0: return 15;
      2'd1: return 13;
      2'd2: return 9;
      default: return 6;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  logic [7:0] mCtl = '0;
  int mCnt = 0;
  logic mFlag = 1'b0, mRst = 1'b0;

  always @(posedge clk) begin
    logic tick, inc, hit, keyOk, keyBad, clrW, expire, puc;
    if (!rstN) begin
      mCtl = '0; mCnt = 0; mFlag = 1'b0; mRst = 1'b0;
    end else begin
      tick   = mCtl[2] ? tickB : tickA;
      inc    = tick && !mCtl[7];
      hit    = inc && ((((mCnt + 1) >> tapOf(mCtl[1:0])) & 1) == 1);
      keyOk  = wrEn && wrData[15:8] == 8'h5A;
      keyBad = wrEn && wrData[15:8] != 8'h5A;
      clrW   = keyOk && wrData[3];
      expire = hit && !keyBad && !clrW;
      puc    = keyBad || (expire && !mCtl[4]);
      mRst   = puc;
      if (keyBad || expire) mFlag = 1'b1;
      else if (flagClr) mFlag = 1'b0;
      if (keyBad || clrW || expire) mCnt = 0;
      else if (inc) mCnt = (mCnt + 1) & 16'hFFFF;
      if (puc) mCtl = '0;
      else if (keyOk) mCtl = wrData[7:0] & 8'hF7;
    end
    #2;
    if (rstN) begin
      chk(rdData == {8'h69, mCtl}, "R1 R2 model rdData", rdData, {8'h69, mCtl});
      chk(rstReq == mRst, "R3 R4 R5 model rstReq", rstReq, mRst);
      chk(irqFlag == mFlag, "R10 model irqFlag", irqFlag, mFlag);
      chk(nmiSel == mCtl[5] && nmiEdge == mCtl[6], "R2 model nmi bits",
          {nmiEdge, nmiSel}, mCtl[6:5]);
    end
  end

  task automatic wr(input logic [15:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clearFlag();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(rdData == 16'h6900, "R11 reset rdData", rdData, 16'h6900);
    chk(!rstReq && !irqFlag, "R11 reset outputs", {rstReq, irqFlag}, 0);

    // R6 R4: default 32768-count watchdog timeout on tickA
    tickA = 1'b1;
    repeat (32767) @(negedge clk);
    chk(!rstReq, "R6 tap15 early", rstReq, 0);
    @(negedge clk);
    chk(rstReq && irqFlag, "R4 watchdog run-out", {rstReq, irqFlag}, 3);
    tickA = 1'b0;
    @(negedge clk);
    chk(!rstReq, "R4 reset one cycle", rstReq, 0);
    clearFlag();
    chk(!irqFlag, "R10 flagClr", irqFlag, 0);

    // R1 R2: keyed write, clear reads 0
    wr(16'h5A7B);
    chk(rdData == 16'h6973, "R1 R2 keyed write", rdData, 16'h6973);
    chk(nmiSel && nmiEdge, "R2 nmi bits", {nmiEdge, nmiSel}, 3);

    // R5 interval mode, 64-count tap
    tickA = 1'b1;
    repeat (63) @(negedge clk);
    chk(!irqFlag, "R5 before run-out", irqFlag, 0);
    @(negedge clk);
    chk(irqFlag && !rstReq, "R5 interval run-out", {rstReq, irqFlag}, 1);
    repeat (63) @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    tickA = 1'b0;
    chk(irqFlag, "R10 set beats clear", irqFlag, 1);
    clearFlag();

    // R8 hold
    wr(16'h5A9B);
    tickA = 1'b1;
    repeat (200) @(negedge clk);
    chk(!irqFlag && !rstReq, "R8 hold freezes", {rstReq, irqFlag}, 0);
    tickA = 1'b0;

    // R9 count-enable select B
    wr(16'h5A1F);
    tickA = 1'b1;
    repeat (100) @(negedge clk);
    chk(!irqFlag, "R9 tickA ignored", irqFlag, 0);
    tickA = 1'b0; tickB = 1'b1;
    repeat (63) @(negedge clk);
    chk(!irqFlag, "R9 tickB early", irqFlag, 0);
    @(negedge clk);
    chk(irqFlag, "R9 tickB run-out", irqFlag, 1);
    tickB = 1'b0;
    clearFlag();

    // R7 clear collides with run-out, 512-count watchdog tap
    wr(16'h5A0A);
    tickA = 1'b1;
    repeat (511) @(negedge clk);
    wr(16'h5A0A);
    chk(!rstReq && !irqFlag, "R7 clear beats run-out", {rstReq, irqFlag}, 0);
    repeat (511) @(negedge clk);
    chk(!rstReq, "R7 restarted count", rstReq, 0);
    @(negedge clk);
    chk(rstReq && rdData == 16'h6900, "R4 R6 tap9 run-out", rdData, 16'h6900);
    tickA = 1'b0;
    clearFlag();

    // R6 tap13 in interval mode
    wr(16'h5A19);
    tickA = 1'b1;
    repeat (8191) @(negedge clk);
    chk(!irqFlag, "R6 tap13 early", irqFlag, 0);
    @(negedge clk);
    chk(irqFlag, "R6 tap13 run-out", irqFlag, 1);
    tickA = 1'b0;
    clearFlag();

    // R3 bad key
    wr(16'h5A10);
    wr(16'hA55A);
    chk(rstReq && irqFlag && rdData == 16'h6900, "R3 bad key", rdData, 16'h6900);
    @(negedge clk);
    chk(!rstReq, "R3 pulse width", rstReq, 0);
    clearFlag();

    // random phase against the model
    for (int i = 0; i < 20000; i++) begin
      logic [7:0] lo;
      wrEn = ($urandom % 40) == 0;
      lo = 8'($urandom);
      if (($urandom % 4) != 0) lo[1:0] = 2'b11;
      if (($urandom % 3) != 0) lo[4] = 1'b1;
      if (($urandom % 4) != 0) lo[7] = 1'b0;
      wrData = (($urandom % 8) == 0) ? {8'($urandom % 90), lo} : {8'h5A, lo};
      tickA = ($urandom % 4) != 0;
      tickB = ($urandom % 4) != 0;
      flagClr = ($urandom % 30) == 0;
      @(negedge clk);
    end
    wrEn = 1'b0; tickA = 1'b0; tickB = 1'b0; flagClr = 1'b0;
    @(negedge clk);
    summary();
  end
endmodule